// File: doc/BRIEF.md
# SHA-256 Message Schedule Expander

This block turns one 512-bit message block into the sixty-four 32-bit schedule words that the SHA-256 compression rounds use, one word per round. It does not store the whole schedule. A register window holds sixteen words, and each accepted output word pushes a freshly mixed word into the tail of that window. The expander therefore runs in step with the compression loop beside it, and its latency is hidden behind the rounds.

Blocks arrive on a valid/ready input. The input is always ready, so any handshake loads a block at once, including one that arrives in the middle of an expansion. Words leave on a valid/ready output that carries the round index with each word. The consumer advances the schedule by completing a handshake. While ready is low the output holds its word and index. Words are never dropped, reordered or skipped. After the word for round 63 is taken, the output goes idle until the next load. Padding, length encoding, the round constants and the compression itself belong to other blocks.

Top module: `msg_sched_expand`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0 and out_idx is 0.
- R2: in_ready is always 1. A cycle with in_valid high loads in_block, and in the next cycle out_valid is 1 and out_idx is 0.
- R3: For rounds 0 to 15 the word is taken straight from the block, most significant word first: W[k] = in_block[511-32k -: 32], so W[0] = in_block[511:480].
- R4: For rounds 16 to 63, W[i] = s1(W[i-2]) + W[i-7] + s0(W[i-15]) + W[i-16] modulo 2^32. Here s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: A cycle with out_valid and out_ready both high, and no load, advances the output. In the next cycle out_idx is one higher and out_word is the next schedule word.
- R6: While out_valid is 1 and out_ready is 0, with no load, out_word and out_idx stay unchanged and out_valid stays 1.
- R7: Once the round-63 word is accepted, out_valid is 0 in the next cycle and out_idx is 0. Both stay that way until the next load, and out_ready has no effect while the output is idle.
- R8: A load that arrives during an expansion restarts it at round 0 with the new block, even when an output handshake happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A block is offered on in_block |
| in_ready | output | 1 | Always 1; a block is accepted whenever in_valid is high |
| in_block | input | 512 | Message block, word 0 in the top 32 bits |
| out_valid | output | 1 | out_word and out_idx hold a schedule word |
| out_ready | input | 1 | Consumer takes the current word and advances the round |
| out_word | output | 32 | Schedule word for round out_idx |
| out_idx | output | 6 | Round index, 0 to 63 |

## Verification
The hardest case to reach from the ports is a load that collides with an output handshake. This matters most when it lands on round 63, where the control wants to retire the expansion and the window wants to shift. The bench drives exactly that cycle: it stops the consumer after 20 words and after 63 words, then raises in_valid and out_ready together. It then checks that round 0 of the new block appears. Stalls are produced by several periodic ready patterns, so every schedule word, including those past 16 that depend on the mixing path, is seen both under pressure and while flowing freely. The input blocks are the single-block "abc" vector, all zeros, all ones and pseudo-random fills.

// File: rtl/msx_pkg.sv
package msx_pkg;
  // rotate and shift amounts of the two small mixing functions
  localparam int S0_ROT_A = 7;
  localparam int S0_ROT_B = 18;
  localparam int S0_SHR   = 3;
  localparam int S1_ROT_A = 17;
  localparam int S1_ROT_B = 19;
  localparam int S1_SHR   = 10;

  // window positions read by the tail mixer, relative to the head word
  localparam int TAP_S0  = 1;
  localparam int TAP_MID = 9;
  localparam int TAP_S1  = 14;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } msx_state_e;
endpackage

// File: rtl/msx_sigma.sv
module msx_sigma #(
  parameter int WORD_W = 32,
  parameter int ROT_A  = 7,
  parameter int ROT_B  = 18,
  parameter int SHR_N  = 3
) (
  input  logic [WORD_W-1:0] x,
  output logic [WORD_W-1:0] y
);
  logic [2*WORD_W-1:0] dbl;
  logic [WORD_W-1:0]   rot_a;
  logic [WORD_W-1:0]   rot_b;
  logic [WORD_W-1:0]   shr;

  assign dbl   = {x, x};
  assign rot_a = dbl[ROT_A +: WORD_W];
  assign rot_b = dbl[ROT_B +: WORD_W];
  assign shr   = x >> SHR_N;
  assign y     = rot_a ^ rot_b ^ shr;
endmodule

// File: rtl/msx_window.sv
module msx_window #(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int TAP_A  = 1,
  parameter int TAP_B  = 9,
  parameter int TAP_C  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  shift,
  input  logic [WIN*WORD_W-1:0] blk,
  input  logic [WORD_W-1:0]     fill,
  output logic [WORD_W-1:0]     head,
  output logic [WORD_W-1:0]     tap_a,
  output logic [WORD_W-1:0]     tap_b,
  output logic [WORD_W-1:0]     tap_c
);
  logic [WORD_W-1:0] slot     [WIN];
  logic [WORD_W-1:0] shifted  [WIN];
  logic [WORD_W-1:0] loaded   [WIN];

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    // slot 0 takes the most significant word of the block
    assign loaded[g] = blk[(WIN-1-g)*WORD_W +: WORD_W];
    if (g == WIN-1) begin : g_tail
      assign shifted[g] = fill;
    end else begin : g_body
      assign shifted[g] = slot[g+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) slot[i] <= '0;
    end else if (load) begin
      slot <= loaded;
    end else if (shift) begin
      slot <= shifted;
    end
  end

  assign head  = slot[0];
  assign tap_a = slot[TAP_A];
  assign tap_b = slot[TAP_B];
  assign tap_c = slot[TAP_C];
endmodule

// File: rtl/msx_ctrl.sv
module msx_ctrl
  import msx_pkg::*;
#(
  parameter int ROUNDS = 64,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  output logic             active,
  output logic             shift,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS-1);

  msx_state_e       state;
  msx_state_e       state_nx;
  logic [IDX_W-1:0] idx_nx;
  logic             fire;

  assign fire = advance && (state == ST_RUN);

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    if (load) begin
      state_nx = ST_RUN;
      idx_nx   = '0;
    end else if (fire) begin
      if (idx == LAST) begin
        state_nx = ST_IDLE;
        idx_nx   = '0;
      end else begin
        idx_nx = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
    end
  end

  assign active = (state == ST_RUN);
  assign shift  = fire && !load;
endmodule

// File: rtl/msg_sched_expand.sv
module msg_sched_expand
  import msx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int ROUNDS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [WIN*WORD_W-1:0]        in_block,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WORD_W-1:0]            out_word,
  output logic [$clog2(ROUNDS)-1:0]    out_idx
);
  localparam int IDX_W = $clog2(ROUNDS);

  logic              shift;
  logic              active;
  logic [WORD_W-1:0] head, tap_s0, tap_mid, tap_s1;
  logic [WORD_W-1:0] mix_s0, mix_s1, fill;

  assign in_ready = 1'b1;

  msx_ctrl #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .load(in_valid),
    .advance(out_ready),
    .active(active),
    .shift(shift),
    .idx(out_idx)
  );

  msx_window #(
    .WORD_W(WORD_W), .WIN(WIN),
    .TAP_A(TAP_S0), .TAP_B(TAP_MID), .TAP_C(TAP_S1)
  ) u_win (
    .clk(clk), .rst(rst),
    .load(in_valid),
    .shift(shift),
    .blk(in_block),
    .fill(fill),
    .head(head),
    .tap_a(tap_s0),
    .tap_b(tap_mid),
    .tap_c(tap_s1)
  );

  msx_sigma #(.WORD_W(WORD_W), .ROT_A(S0_ROT_A), .ROT_B(S0_ROT_B), .SHR_N(S0_SHR))
    u_sig0 (.x(tap_s0), .y(mix_s0));
  msx_sigma #(.WORD_W(WORD_W), .ROT_A(S1_ROT_A), .ROT_B(S1_ROT_B), .SHR_N(S1_SHR))
    u_sig1 (.x(tap_s1), .y(mix_s1));

  // word that enters the tail: the head word is i-16 relative to the new one
  assign fill = mix_s1 + tap_mid + mix_s0 + head;

  assign out_valid = active;
  assign out_word  = head;
endmodule

// File: rtl/msx_checker.sv
module msx_checker #(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int ROUNDS = 64,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [WIN*WORD_W-1:0] in_block,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WORD_W-1:0]     out_word,
  input logic [IDX_W-1:0]      out_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS-1);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_idx == '0));

  p_first_word_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word == $past(in_block[WIN*WORD_W-1 -: WORD_W])));

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid && out_idx != LAST)
      |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !in_valid)
      |=> (out_valid && $stable(out_word) && $stable(out_idx)));

  p_retire_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid && out_idx == LAST)
      |=> (!out_valid && out_idx == '0));

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_valid) |=> (!out_valid && out_idx == '0));

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_valid && out_ready) |=> (out_idx == '0));
endmodule

bind msg_sched_expand msx_checker #(
  .WORD_W(WORD_W), .WIN(WIN), .ROUNDS(ROUNDS), .IDX_W($clog2(ROUNDS))
) u_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_block(in_block),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_idx(out_idx)
);

// File: tb/sim_msg_sched_expand.sv
module sim_msg_sched_expand;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [511:0] in_block;
  logic         out_valid;
  logic         out_ready;
  logic [31:0]  out_word;
  logic [5:0]   out_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] wexp [64];

  always #5 clk = ~clk;

  msg_sched_expand u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_block(in_block),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_idx(out_idx)
  );

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic void build(input logic [511:0] b);
    for (int k = 0; k < 16; k++) wexp[k] = b[511 - 32*k -: 32];
    for (int i = 16; i < 64; i++) begin
      logic [31:0] a, c;
      a = rotr(wexp[i-15], 7) ^ rotr(wexp[i-15], 18) ^ (wexp[i-15] >> 3);
      c = rotr(wexp[i-2], 17) ^ rotr(wexp[i-2], 19) ^ (wexp[i-2] >> 10);
      wexp[i] = c + wexp[i-7] + a + wexp[i-16];
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_block(input logic [511:0] b, input bit rdy);
    in_valid  = 1'b1;
    in_block  = b;
    out_ready = rdy;
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    build(b);
    chk(out_valid == 1'b1, "R2 valid after load", 32'(out_valid), 32'd1);
    chk(out_idx == 6'd0, "R2 index after load", 32'(out_idx), 32'd0);
  endtask

  // mode 0: always ready; 1: ready two of three; 2: ready one of four
  task automatic stream(input int nwords, input int mode);
    int k = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    while (k < nwords && cyc < 1000) begin
      bit rdy;
      string tag;
      tag = stalled ? "R6 hold" : (k < 16 ? "R3 block word" : "R4 mixed word");
      chk(out_valid == 1'b1, "R5 valid in stream", 32'(out_valid), 32'd1);
      chk(out_idx == 6'(k), tag, 32'(out_idx), 32'(k));
      chk(out_word == wexp[k], tag, out_word, wexp[k]);
      case (mode)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 3) != 0;
        default: rdy = (cyc % 4) == 3;
      endcase
      out_ready = rdy;
      @(negedge clk);
      if (rdy) k++;
      stalled = !rdy;
      cyc++;
    end
    out_ready = 1'b0;
  endtask

  task automatic check_idle;
    chk(out_valid == 1'b0, "R7 idle after last", 32'(out_valid), 32'd0);
    chk(out_idx == 6'd0, "R7 index idle", 32'(out_idx), 32'd0);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R7 ready ignored when idle", 32'(out_valid), 32'd0);
    chk(out_idx == 6'd0, "R7 index held idle", 32'(out_idx), 32'd0);
  endtask

  function automatic logic [511:0] lcg_block(input logic [31:0] seed);
    logic [511:0] b;
    logic [31:0] x = seed;
    for (int k = 0; k < 16; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      b[511 - 32*k -: 32] = x;
    end
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] abc;
    rst = 1'b1; in_valid = 1'b0; in_block = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
    chk(out_idx == 6'd0, "R1 reset index", 32'(out_idx), 32'd0);
    chk(in_ready == 1'b1, "R2 input ready", 32'(in_ready), 32'd1);

    // single-block "abc" vector: message bytes, the 0x80 pad marker, then length 24
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;
    load_block(abc, 1'b0);
    stream(64, 0);
    check_idle();

    for (int m = 0; m < 3; m++) begin
      logic [511:0] b;
      b = (m == 0) ? '0 : (m == 1) ? '1 : lcg_block(32'h1234_5678);
      load_block(b, 1'b0);
      stream(64, m);
      check_idle();
    end

    // R8: restart in mid-stream with an advance in the same cycle
    load_block(lcg_block(32'hCAFE_0001), 1'b0);
    stream(20, 1);
    load_block(lcg_block(32'h0BAD_F00D), 1'b1);
    chk(out_word == wexp[0], "R8 restart word", out_word, wexp[0]);
    stream(63, 2);
    // R8: restart on the last round while it is being accepted
    load_block(abc, 1'b1);
    chk(out_word == wexp[0], "R8 restart at last round", out_word, wexp[0]);
    stream(64, 1);
    check_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule